// File: doc/BRIEF.md
# NAND Power-Up Initialization Sequencer

This block brings a group of NAND flash dies from power-on to a usable state. While the supply-good input is low it holds write-protect active and blocks all command traffic. After the supply becomes valid it waits a programmable settle time. It then sends the reset opcode FFh to each die in turn, using a one-hot active-low chip-enable, and after each reset it waits for the shared open-drain ready/busy line to report ready.

During that reset busy time the host may still send the two status reads (70h and 78h). Every other request is refused until the sequence has finished. If the line stays busy past a limit derived from the clock frequency and a busy time in microseconds, a sticky error flag is set and the sequence stops. When every die has been reset and has come back ready, init-done rises, write-protect is released, and all host commands pass through.

The ready/busy input is treated as asynchronous. It goes through two flip-flops, and each reset is followed by a blanking window during which the line is not sampled. This keeps a stale "ready" value from being taken as the end of the busy time.

Top module: `nand_pwrup_seq`

## Requirements
- R1: Out of reset, write-protect is low (active), init-done is 0, the error flag is 0, no command strobe is issued, all chip-enables are high, and no host request is granted.
- R2: While supply-good is low, the block returns to its protected idle state. From the next clock onward, write-protect is low, init-done is 0 and no strobe is issued.
- R3: The first reset strobe appears on the bus output after the clock edge that lies SETTLE_CYC+2 edges after the first edge that samples supply-good high.
- R4: Each bus strobe selects exactly one die, by driving its chip-enable bit low (bit i belongs to die i). The reset opcode FFh goes to every die, once each, in ascending index order.
- R5: Ready/busy is active low (high means ready). It is sampled only through a two-flip-flop synchronizer and only after a BLANK_CYC-cycle blanking window following each reset. A die that is ready at once therefore finishes BLANK_CYC+1 cycles after its reset strobe.
- R6: The next die's reset is sent only after the shared line has read ready. With a busy time of L cycles (L ≥ BLANK_CYC-2), the next reset strobe follows the previous one by L+4 cycles.
- R7: If the line is still busy TO_CYC = CLK_KHZ*BUSY_LIMIT_US/1000 cycles after a reset strobe, the error flag rises at exactly that distance. No further die is reset, init-done stays 0 and write-protect stays low.
- R8: Init-done and write-protect release (output high) both assert only after the last die has read ready.
- R9: Before the first reset strobe (while idle or settling) and in the cycle that issues a reset, no host request is granted.
- R10: While a die is busy after reset, and after a timeout, only opcodes 70h and 78h are granted. Any other request gets no grant and produces no bus strobe.
- R11: After init-done, any host request is granted combinationally. The following cycle it appears on the bus as a strobe with its opcode and the requested die's chip-enable low.
- R12: The error flag is sticky. A supply-good drop does not clear it; only the reset input does.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pwr_good_i | input | 1 | Supply valid indication, synchronous to clk |
| rb_n_i | input | 1 | Shared open-drain ready/busy line, low = busy, asynchronous |
| host_cmd_valid_i | input | 1 | Host command request |
| host_cmd_i | input | 8 | Host command opcode |
| host_die_i | input | DIE_W | Die targeted by the host command |
| host_grant_o | output | 1 | Host request accepted this cycle |
| bus_strobe_o | output | 1 | One-cycle command strobe on the bus |
| bus_opcode_o | output | 8 | Opcode on the bus, valid with the strobe |
| bus_ce_n_o | output | NUM_DIES | Active-low chip-enable per die |
| wp_n_o | output | 1 | Write-protect, low = protected |
| init_done_o | output | 1 | All dies reset and ready |
| timeout_err_o | output | 1 | Sticky busy-timeout error |

## Verification
The assertions assume that supply-good and the host request signals are synchronous to the clock, and that host_die_i always names an existing die. They also assume that the ready line, although asynchronous, holds each level long enough for the synchronizer to catch it. The ready-before-release check looks back three cycles, which depends on the two-stage synchronizer in front of the state machine. The bench changes every input one nanosecond after a rising edge and emulates the dies as busy counters on a wired-AND ready line. Each die's busy time is at least BLANK_CYC-2 cycles or zero, so the stimulus never depends on ready-line behaviour that the blanking window is not meant to cover.

// File: rtl/nand_init_pkg.sv
package nand_init_pkg;

    typedef enum logic [2:0] {
        ST_OFF,
        ST_SETTLE,
        ST_ISSUE,
        ST_BLANK,
        ST_WAIT,
        ST_DONE,
        ST_FAULT
    } init_state_e;

    localparam logic [7:0] OP_RESET      = 8'hFF;
    localparam logic [7:0] OP_STATUS     = 8'h70;
    localparam logic [7:0] OP_STATUS_ENH = 8'h78;

endpackage

// File: rtl/nand_rb_sync.sv
module nand_rb_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_i,
    output logic sync_o
);
    logic [STAGES-1:0] chain_q;

    generate
        if (STAGES == 1) begin : g_single
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain_q <= 1'b1;
                else        chain_q <= async_i;
            end
        end else begin : g_multi
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain_q <= '1;
                else        chain_q <= {chain_q[STAGES-2:0], async_i};
            end
        end
    endgenerate

    assign sync_o = chain_q[STAGES-1];
endmodule

// File: rtl/nand_cmd_gate.sv
module nand_cmd_gate
    import nand_init_pkg::*;
(
    input  init_state_e state_i,
    input  logic        pwr_good_i,
    input  logic        cmd_valid_i,
    input  logic [7:0]  cmd_i,
    output logic        grant_o
);
    logic is_status;
    logic allow;

    always_comb begin
        is_status = (cmd_i == OP_STATUS) || (cmd_i == OP_STATUS_ENH);
        case (state_i)
            ST_DONE:                     allow = 1'b1;
            ST_BLANK, ST_WAIT, ST_FAULT: allow = is_status;
            default:                     allow = 1'b0;
        endcase
        grant_o = cmd_valid_i && pwr_good_i && allow;
    end
endmodule

// File: rtl/nand_pwrup_seq.sv
module nand_pwrup_seq
    import nand_init_pkg::*;
#(
    parameter int NUM_DIES      = 2,
    parameter int CLK_KHZ       = 200000,
    parameter int BUSY_LIMIT_US = 2000,
    parameter int SETTLE_CYC    = 64,
    parameter int BLANK_CYC     = 4,
    parameter int DIE_W         = (NUM_DIES > 1) ? $clog2(NUM_DIES) : 1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                pwr_good_i,
    input  logic                rb_n_i,
    input  logic                host_cmd_valid_i,
    input  logic [7:0]          host_cmd_i,
    input  logic [DIE_W-1:0]    host_die_i,
    output logic                host_grant_o,
    output logic                bus_strobe_o,
    output logic [7:0]          bus_opcode_o,
    output logic [NUM_DIES-1:0] bus_ce_n_o,
    output logic                wp_n_o,
    output logic                init_done_o,
    output logic                timeout_err_o
);
    localparam int TO_CYC  = CLK_KHZ * BUSY_LIMIT_US / 1000;
    localparam int AGE_W   = $clog2(TO_CYC + 1);
    localparam int CNT_MAX = (SETTLE_CYC > BLANK_CYC) ? SETTLE_CYC : BLANK_CYC;
    localparam int CNT_W   = $clog2(CNT_MAX + 1);

    typedef struct packed {
        init_state_e         st;
        logic [CNT_W-1:0]    cnt;
        logic [AGE_W-1:0]    age;
        logic [DIE_W-1:0]    die;
        logic                strobe;
        logic [7:0]          op;
        logic [NUM_DIES-1:0] ce_n;
        logic                wp_n;
        logic                done;
        logic                err;
    } seq_regs_t;

    localparam seq_regs_t RESET_VAL = '{
        st: ST_OFF, cnt: '0, age: '0, die: '0, strobe: 1'b0, op: '0,
        ce_n: '1, wp_n: 1'b0, done: 1'b0, err: 1'b0
    };

    seq_regs_t q, d;
    logic      rb_ready;
    logic      grant;

    nand_rb_sync #(.STAGES(2)) rb_sync_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (rb_n_i),
        .sync_o  (rb_ready)
    );

    nand_cmd_gate gate_i (
        .state_i     (q.st),
        .pwr_good_i  (pwr_good_i),
        .cmd_valid_i (host_cmd_valid_i),
        .cmd_i       (host_cmd_i),
        .grant_o     (grant)
    );

    always_comb begin
        d        = q;
        d.strobe = 1'b0;
        d.ce_n   = '1;
        case (q.st)
            ST_OFF: begin
                d.cnt = '0;
                d.age = '0;
                d.die = '0;
                if (pwr_good_i) d.st = ST_SETTLE;
            end
            ST_SETTLE: begin
                if (q.cnt == CNT_W'(SETTLE_CYC - 1)) begin
                    d.st  = ST_ISSUE;
                    d.cnt = '0;
                    d.die = '0;
                end else begin
                    d.cnt = q.cnt + CNT_W'(1);
                end
            end
            ST_ISSUE: begin
                d.strobe = 1'b1;
                d.op     = OP_RESET;
                d.ce_n   = ~(NUM_DIES'(1) << q.die);
                d.st     = ST_BLANK;
                d.cnt    = '0;
                d.age    = '0;
            end
            ST_BLANK: begin
                d.age = q.age + AGE_W'(1);
                if (q.cnt == CNT_W'(BLANK_CYC - 1)) d.st = ST_WAIT;
                else                                d.cnt = q.cnt + CNT_W'(1);
            end
            ST_WAIT: begin
                d.age = q.age + AGE_W'(1);
                if (rb_ready) begin
                    if (q.die == DIE_W'(NUM_DIES - 1)) begin
                        d.st = ST_DONE;
                    end else begin
                        d.die = q.die + DIE_W'(1);
                        d.st  = ST_ISSUE;
                    end
                end else if (q.age == AGE_W'(TO_CYC - 1)) begin
                    d.st  = ST_FAULT;
                    d.err = 1'b1;
                end
            end
            default: ;
        endcase

        if (grant) begin
            d.strobe = 1'b1;
            d.op     = host_cmd_i;
            d.ce_n   = ~(NUM_DIES'(1) << host_die_i);
        end

        if (!pwr_good_i) begin
            d.st     = ST_OFF;
            d.strobe = 1'b0;
            d.ce_n   = '1;
        end

        d.done = (d.st == ST_DONE);
        d.wp_n = (d.st == ST_DONE);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= RESET_VAL;
        else        q <= d;
    end

    assign host_grant_o  = grant;
    assign bus_strobe_o  = q.strobe;
    assign bus_opcode_o  = q.op;
    assign bus_ce_n_o    = q.ce_n;
    assign wp_n_o        = q.wp_n;
    assign init_done_o   = q.done;
    assign timeout_err_o = q.err;
endmodule

// File: rtl/nand_pwrup_seq_chk.sv
module nand_pwrup_seq_chk #(
    parameter int NUM_DIES = 2
) (
    input logic                clk,
    input logic                rst_n,
    input logic                pwr_good_i,
    input logic                rb_n_i,
    input logic [7:0]          host_cmd_i,
    input logic                host_grant_o,
    input logic                bus_strobe_o,
    input logic [7:0]          bus_opcode_o,
    input logic [NUM_DIES-1:0] bus_ce_n_o,
    input logic                wp_n_o,
    input logic                init_done_o,
    input logic                timeout_err_o
);
    a_r2_power_drop_protects: assert property (@(posedge clk) disable iff (!rst_n)
        !pwr_good_i |=> (!wp_n_o && !init_done_o && !bus_strobe_o));

    a_r4_single_die_select: assert property (@(posedge clk) disable iff (!rst_n)
        bus_strobe_o |-> ($countones(bus_ce_n_o) == NUM_DIES - 1));

    a_r10_busy_gate: assert property (@(posedge clk) disable iff (!rst_n)
        (host_grant_o && !init_done_o) |-> (host_cmd_i == 8'h70 || host_cmd_i == 8'h78));

    a_r11_grant_reaches_bus: assert property (@(posedge clk) disable iff (!rst_n)
        host_grant_o |=> (bus_strobe_o && bus_opcode_o == $past(host_cmd_i)));

    a_r12_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        timeout_err_o |=> timeout_err_o);

    a_r7_no_done_on_timeout: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(timeout_err_o) |-> !init_done_o);

    a_r8_done_after_ready: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(init_done_o) |-> ($past(rb_n_i, 3) && wp_n_o));
endmodule

bind nand_pwrup_seq nand_pwrup_seq_chk #(.NUM_DIES(NUM_DIES)) chk_i (
    .clk           (clk),
    .rst_n         (rst_n),
    .pwr_good_i    (pwr_good_i),
    .rb_n_i        (rb_n_i),
    .host_cmd_i    (host_cmd_i),
    .host_grant_o  (host_grant_o),
    .bus_strobe_o  (bus_strobe_o),
    .bus_opcode_o  (bus_opcode_o),
    .bus_ce_n_o    (bus_ce_n_o),
    .wp_n_o        (wp_n_o),
    .init_done_o   (init_done_o),
    .timeout_err_o (timeout_err_o)
);

// File: tb/nand_pwrup_seq_tb_top.sv
`timescale 1ns/1ps
module nand_pwrup_seq_tb_top;
    localparam int N  = 3;
    localparam int S  = 20;
    localparam int B  = 4;
    localparam int TO = 200;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       pg = 1'b0;
    logic       rb = 1'b1;
    logic       hv = 1'b0;
    logic [7:0] hc = 8'h00;
    logic [1:0] hd = 2'd0;

    logic         host_grant_o, bus_strobe_o, wp_n_o, init_done_o, timeout_err_o;
    logic [7:0]   bus_opcode_o;
    logic [N-1:0] bus_ce_n_o;

    always #2.5 clk = ~clk;

    nand_pwrup_seq #(
        .NUM_DIES(N), .CLK_KHZ(200000), .BUSY_LIMIT_US(1),
        .SETTLE_CYC(S), .BLANK_CYC(B)
    ) dut_i (
        .clk(clk), .rst_n(rst_n), .pwr_good_i(pg), .rb_n_i(rb),
        .host_cmd_valid_i(hv), .host_cmd_i(hc), .host_die_i(hd),
        .host_grant_o(host_grant_o), .bus_strobe_o(bus_strobe_o),
        .bus_opcode_o(bus_opcode_o), .bus_ce_n_o(bus_ce_n_o),
        .wp_n_o(wp_n_o), .init_done_o(init_done_o), .timeout_err_o(timeout_err_o)
    );

    int nchk = 0;
    int nfail = 0;

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
        end
    endtask

    // die emulation: busy counters on a wired-AND ready line
    int dlen [N];
    int busy [N];
    int cyc = 0;
    int rst_t [$];
    int rst_die [$];
    int done_t = 0;
    int err_t = 0;
    bit prev_done = 0;
    bit prev_err = 0;

    always @(posedge clk) begin
        #1;
        cyc++;
        for (int i = 0; i < N; i++) if (busy[i] > 0) busy[i]--;
        if (bus_strobe_o && bus_opcode_o == 8'hFF) begin
            for (int i = 0; i < N; i++) begin
                if (!bus_ce_n_o[i]) begin
                    busy[i] = dlen[i];
                    rst_t.push_back(cyc);
                    rst_die.push_back(i);
                end
            end
        end
        rb = 1'b1;
        for (int i = 0; i < N; i++) if (busy[i] != 0) rb = 1'b0;
        if (init_done_o && !prev_done) done_t = cyc;
        if (timeout_err_o && !prev_err) err_t = cyc;
        prev_done = init_done_o;
        prev_err  = timeout_err_o;
    end

    // behavioural reference: phases 0 off,1 settle,2 issue,3 blank,4 wait,5 done,6 fault
    int         m_ph, m_settle, m_blank, m_age, m_die;
    bit         m_err, m_strobe, m_rb1, m_rb2, m_live;
    logic [7:0] m_op;
    logic [N-1:0] m_ce_n;

    function automatic bit m_allow(input int ph, input logic [7:0] c);
        if (ph == 5) return 1'b1;
        if (ph == 3 || ph == 4 || ph == 6) return (c == 8'h70 || c == 8'h78);
        return 1'b0;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_ph = 0; m_settle = 0; m_blank = 0; m_age = 0; m_die = 0;
            m_err = 0; m_strobe = 0; m_op = 8'h00; m_ce_n = '1;
            m_rb1 = 1; m_rb2 = 1; m_live = 1;
        end else begin
            bit g;
            bit rdy;
            g = hv && pg && m_allow(m_ph, hc);
            rdy = m_rb2;
            m_strobe = 0;
            m_ce_n = '1;
            case (m_ph)
                0: if (pg) begin m_ph = 1; m_settle = S; end
                1: begin
                    m_settle--;
                    if (m_settle == 0) begin m_ph = 2; m_die = 0; end
                end
                2: begin
                    m_strobe = 1; m_op = 8'hFF; m_ce_n = ~(N'(1) << m_die);
                    m_ph = 3; m_blank = B; m_age = 0;
                end
                3: begin
                    m_age++; m_blank--;
                    if (m_blank == 0) m_ph = 4;
                end
                4: begin
                    if (rdy) begin
                        if (m_die == N - 1) m_ph = 5;
                        else begin m_die++; m_ph = 2; end
                    end else if (m_age == TO - 1) begin
                        m_ph = 6; m_err = 1;
                    end
                    m_age++;
                end
                default: ;
            endcase
            if (g) begin m_strobe = 1; m_op = hc; m_ce_n = ~(N'(1) << hd); end
            if (!pg) begin m_ph = 0; m_strobe = 0; m_ce_n = '1; end
            m_rb2 = m_rb1;
            m_rb1 = rb;
        end
    end

    always @(negedge clk) begin
        if (rst_n && m_live) begin
            check(wp_n_o == (m_ph == 5), "R8 wp_n", wp_n_o, (m_ph == 5));
            check(init_done_o == (m_ph == 5), "R8 done", init_done_o, (m_ph == 5));
            check(timeout_err_o == m_err, "R7 err", timeout_err_o, m_err);
            check(bus_strobe_o == m_strobe, "R4,R6 strobe", bus_strobe_o, m_strobe);
            if (m_strobe) begin
                check(bus_opcode_o == m_op, "R4 opcode", bus_opcode_o, m_op);
                check(bus_ce_n_o == m_ce_n, "R4 ce_n", bus_ce_n_o, m_ce_n);
            end
            check(host_grant_o == (hv && pg && m_allow(m_ph, hc)), "R10 grant",
                  host_grant_o, (hv && pg && m_allow(m_ph, hc)));
        end
    end

    int wd = 0;
    always @(posedge clk) begin
        wd++;
        if (wd > 20000) begin
            nchk++; nfail++;
            $display("FAIL watchdog: actual %0d expected below 20000 cycles", wd);
            $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
            $finish;
        end
    end

    task automatic step;
        @(posedge clk); #1;
    endtask

    initial begin
        int n;
        dlen[0] = 8; dlen[1] = 15; dlen[2] = 0;
        for (int i = 0; i < N; i++) busy[i] = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1 reset state
        check(wp_n_o == 0, "R1 wp_n", wp_n_o, 0);
        check(init_done_o == 0, "R1 done", init_done_o, 0);
        check(timeout_err_o == 0, "R1 err", timeout_err_o, 0);
        check(bus_strobe_o == 0, "R1 strobe", bus_strobe_o, 0);
        check(bus_ce_n_o == 3'b111, "R1 ce_n", bus_ce_n_o, 3'b111);
        check(host_grant_o == 0, "R1 grant", host_grant_o, 0);
        step(); rst_n = 1;
        step(); step();
        // R9: nothing granted while idle
        hv = 1; hc = 8'h70; hd = 0;
        @(negedge clk);
        check(host_grant_o == 0, "R9 idle grant", host_grant_o, 0);
        step(); hc = 8'h00;
        // R3: settle delay
        pg = 1; n = 0;
        do begin step(); n++; end while (!bus_strobe_o && n < 200);
        check(n == S + 2, "R3 settle edges", n, S + 2);
        check(bus_opcode_o == 8'hFF && bus_ce_n_o == 3'b110, "R4 first reset die0",
              {bus_opcode_o, 5'b0, bus_ce_n_o}, {8'hFF, 8'h06});
        // R10: non-status refused while busy, status passes
        hv = 1; hc = 8'h00; hd = 0;
        @(negedge clk);
        check(host_grant_o == 0, "R10 refuse 00h", host_grant_o, 0);
        step();
        check(bus_strobe_o == 0, "R10 no strobe for 00h", bus_strobe_o, 0);
        hc = 8'h70;
        @(negedge clk);
        check(host_grant_o == 1, "R10 grant 70h", host_grant_o, 1);
        step();
        check(bus_strobe_o && bus_opcode_o == 8'h70, "R10 70h on bus",
              bus_opcode_o, 8'h70);
        hv = 0;
        n = 0;
        while (!init_done_o && n < 1000) begin step(); n++; end
        #1;
        // R4 order, R6 spacing, R5 blanking
        check(rst_die.size() == 3, "R4 reset count", rst_die.size(), 3);
        if (rst_die.size() == 3) begin
            for (int i = 0; i < 3; i++) check(rst_die[i] == i, "R4 ascending order", rst_die[i], i);
            check(rst_t[1] - rst_t[0] == dlen[0] + 4, "R6 gap die0", rst_t[1] - rst_t[0], dlen[0] + 4);
            check(rst_t[2] - rst_t[1] == dlen[1] + 4, "R6 gap die1", rst_t[2] - rst_t[1], dlen[1] + 4);
            check(done_t - rst_t[2] == B + 1, "R5 blank then done", done_t - rst_t[2], B + 1);
        end
        check(wp_n_o == 1 && init_done_o == 1, "R8 released", {wp_n_o, init_done_o}, 2'b11);
        // R11: any command after done
        hv = 1; hc = 8'h00; hd = 1;
        @(negedge clk);
        check(host_grant_o == 1, "R11 grant", host_grant_o, 1);
        step(); hv = 0;
        check(bus_strobe_o == 1 && bus_opcode_o == 8'h00, "R11 opcode", bus_opcode_o, 8'h00);
        check(bus_ce_n_o == 3'b101, "R11 ce_n", bus_ce_n_o, 3'b101);
        // R2: supply drop
        step(); pg = 0;
        step();
        check(wp_n_o == 0 && init_done_o == 0, "R2 protect", {wp_n_o, init_done_o}, 0);
        step(); step();
        // timeout run
        rst_t.delete(); rst_die.delete();
        for (int i = 0; i < N; i++) dlen[i] = 300;
        pg = 1; n = 0;
        while (!timeout_err_o && n < 1000) begin step(); n++; end
        #1;
        check(timeout_err_o == 1, "R7 err set", timeout_err_o, 1);
        check(init_done_o == 0 && wp_n_o == 0, "R7 stays protected", {wp_n_o, init_done_o}, 0);
        check(rst_t.size() == 1, "R7 no further reset", rst_t.size(), 1);
        if (rst_t.size() >= 1) check(err_t - rst_t[0] == TO, "R7 limit", err_t - rst_t[0], TO);
        step();
        hv = 1; hc = 8'h78; hd = 2;
        @(negedge clk);
        check(host_grant_o == 1, "R10 78h after timeout", host_grant_o, 1);
        step(); hc = 8'h90;
        @(negedge clk);
        check(host_grant_o == 0, "R10 refuse 90h after timeout", host_grant_o, 0);
        step(); hv = 0;
        // R12 sticky across supply drop, cleared by reset
        pg = 0;
        repeat (3) step();
        check(timeout_err_o == 1, "R12 survives supply drop", timeout_err_o, 1);
        rst_n = 0; #1;
        check(timeout_err_o == 0, "R12 cleared by reset", timeout_err_o, 0);
        repeat (2) step();
        $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
        $finish;
    end
endmodule